// File: doc/BRIEF.md
# Dual-Enable Write-Protectable SRAM

This block is a clocked model of an 8192 x 8 byte-wide static memory behind a bus that has two chip selects of opposite polarity, an output enable and a write enable. It also has a lock input, driven by a power-fail supervisor. Every control pin is sampled on the rising edge of the system clock. The block rebuilds the edge-referenced write window of an asynchronous memory from those sampled levels. A write window opens on the sample where the last of its three qualifying controls becomes active. The byte is stored on the sample where the first of them drops. The data pins are split into an input byte, an output byte and a drive flag. A pad ring or a bus model turns these into a tri-state byte.

When the lock input is high, the block ignores the bus. The output drive flag goes low and no write can reach the array. A window that the lock cuts off stores nothing. A new window cannot open until the write controls have been released once.

Top module: `pf_sram`

## Requirements
- R1: The array holds 8192 bytes selected by a 13-bit address. A committed byte reads back from its own address, and every other address keeps its contents.
- R2: The chip is selected only while `sel_n` is low and `sel` is high. In any other sample, `dout_en` is 0 in the following cycle.
- R3: A read is sampled when the chip is selected, `we_n` is high, `oe_n` is low and `lock` is low. One cycle later, `dout_en` is 1 and `dout` carries the addressed byte. When `oe_n` is high, `dout_en` is 0.
- R4: A write window is open while the chip is selected and `we_n` is low. Whichever of `we_n`, `sel_n` or `sel` becomes active last opens the window. On the first sample where any of them is inactive, the byte on `din` is stored at `addr`, both taken from that same sample.
- R5: If `we_n` is sampled low while a read is being driven, `dout_en` is 0 in the next cycle.
- R6: If a chip select becomes active in the same sample in which `we_n` goes low, `dout_en` stays 0 for the whole window.
- R7: While `lock` is sampled high, all other inputs are ignored. `dout_en` is 0 in the next cycle, and no write sequence changes the array.
- R8: A window that is open when `lock` rises stores nothing. Another window opens only after the write controls have been inactive for at least one sample.
- R9: Whenever `dout_en` is 0, `dout` is all zeros.
- R10: A read sampled on the same edge that commits a write returns the byte being written.
- R11: After reset, `dout_en` is 0, `dout` is 0, and no write window is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 13 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Registered read data; zero when not driving |
| dout_en | output | 1 | Output drive flag for the data byte |
| sel_n | input | 1 | Active-low chip select |
| sel | input | 1 | Active-high chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| lock | input | 1 | Power-fail deselect and write protect, active high |

## Verification
Some rules are checked by the assertions on every cycle: the one-cycle read latency, output release after deselect, after a low write enable and under lock, and zero data while not driving. The bench scenarios are needed for everything that involves array contents. This covers which of the three controls opens and closes a window, and that a lock-aborted window stays blocked after the lock drops. It also covers that neighbouring addresses survive, and the forwarding of a byte committed on the same edge as a read.

// File: rtl/pf_sram_pkg.sv
package pf_sram_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE   = 2'd0,
    BUS_READ   = 2'd1,
    BUS_WRITE  = 2'd2,
    BUS_LOCKED = 2'd3
  } bus_mode_e;

  // Both selects must agree for the chip to respond.
  function automatic logic chip_on(input logic s_n, input logic s);
    return (!s_n) && s;
  endfunction

  // Lock wins over everything, then select, then write over read.
  function automatic bus_mode_e decode_mode(input logic lk, input logic s_n,
                                            input logic s, input logic o_n,
                                            input logic w_n);
    if (lk)                   return BUS_LOCKED;
    else if (!chip_on(s_n, s)) return BUS_IDLE;
    else if (!w_n)            return BUS_WRITE;
    else if (!o_n)            return BUS_READ;
    else                      return BUS_IDLE;
  endfunction

endpackage

// File: rtl/pf_sram_ctrl.sv
module pf_sram_ctrl
  import pf_sram_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic sel,
  input  logic oe_n,
  input  logic we_n,
  input  logic lock,
  output logic rd_go,
  output logic wr_commit,
  output logic win_open
);

  bus_mode_e mode;
  logic      raw_req;
  logic      win_q;
  logic      blk_q;
  logic      win_d;
  logic      blk_d;

  assign mode    = decode_mode(lock, sel_n, sel, oe_n, we_n);
  assign raw_req = chip_on(sel_n, sel) && !we_n;

  // Window may open only if not blocked by an earlier lock event.
  assign win_d   = (mode == BUS_WRITE) && !blk_q;
  // Block persists while write controls stay asserted after a lock.
  assign blk_d   = raw_req && (lock || blk_q);

  assign wr_commit = win_q && !raw_req && !lock;
  assign rd_go     = (mode == BUS_READ);
  assign win_open  = win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= 1'b0;
      blk_q <= 1'b0;
    end else begin
      win_q <= win_d;
      blk_q <= blk_d;
    end
  end

endmodule

// File: rtl/pf_sram_store.sv
module pf_sram_store #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  input  logic              rd,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) mem[addr] <= wdata;
  end

  // Registered read port with forwarding of a same-edge commit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= wr ? wdata : mem[addr];
      else    rdata <= '0;
    end
  end

endmodule

// File: rtl/pf_sram.sv
module pf_sram #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  input  logic              sel_n,
  input  logic              sel,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              lock
);

  logic rd_go;
  logic wr_commit;
  logic win_open;

  pf_sram_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_n     (sel_n),
    .sel       (sel),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .lock      (lock),
    .rd_go     (rd_go),
    .wr_commit (wr_commit),
    .win_open  (win_open)
  );

  pf_sram_store #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (addr),
    .wdata  (din),
    .wr     (wr_commit),
    .rd     (rd_go),
    .rdata  (dout),
    .rvalid (dout_en)
  );

  // Port-level checks of the read path and output release.
  p_rd_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && sel && we_n && !oe_n && !lock) |=> dout_en);

  p_desel_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sel_n && sel) |=> !dout_en);

  p_we_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |=> !dout_en);

  p_lock_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> !dout_en);

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == '0));

  p_commit_needs_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(!we_n && !sel_n && sel));

endmodule

// File: tb/test_pf_sram.sv
module test_pf_sram;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dout_en;
  logic        sel_n = 1'b1;
  logic        sel = 1'b0;
  logic        oe_n = 1'b1;
  logic        we_n = 1'b1;
  logic        lock = 1'b0;

  int total = 0;
  int bad = 0;
  logic [7:0] expq [$];
  logic [7:0] shadow [logic [12:0]];

  always #4 clk = ~clk;

  pf_sram i_pf_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .dout(dout),
    .dout_en(dout_en), .sel_n(sel_n), .sel(sel), .oe_n(oe_n),
    .we_n(we_n), .lock(lock)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic a_sn, input logic a_s, input logic a_on,
                     input logic a_wn, input logic a_lk,
                     input logic [12:0] a_ad, input logic [7:0] a_d);
    sel_n = a_sn; sel = a_s; oe_n = a_on; we_n = a_wn; lock = a_lk;
    addr = a_ad; din = a_d;
    @(negedge clk);
  endtask

  task automatic idle();
    put(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, addr, din);
  endtask

  task automatic do_read(input logic [12:0] a);
    expq.push_back(shadow[a]);
    put(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, a, 8'h00);
    idle();
  endtask

  // R4: write enable opens last and closes first
  task automatic wr_we(input logic [12:0] a, input logic [7:0] d);
    put(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, a, d);
    put(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, a, d);
    put(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, a, d);
    put(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, a, d);
    shadow[a] = d;
    idle();
  endtask

  // R4: active-low select opens last and closes first
  task automatic wr_cs_lo(input logic [12:0] a, input logic [7:0] d);
    put(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, a, d);
    put(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, a, d);
    put(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, a, d);
    shadow[a] = d;
    idle();
  endtask

  // R4: active-high select opens last and closes first
  task automatic wr_cs_hi(input logic [12:0] a, input logic [7:0] d);
    put(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, a, d);
    put(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, a, d);
    put(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, a, d);
    shadow[a] = d;
    idle();
  endtask

  // Scoreboard monitor: every driven byte must match a queued read.
  always @(posedge clk) begin
    #2;
    if (rst_n && dout_en) begin
      total++;
      if (expq.size() == 0) begin
        bad++;
        $display("FAIL R2/R5/R6/R7 unexpected drive act=%0h exp=none", dout);
      end else begin
        logic [7:0] e;
        e = expq.pop_front();
        if (dout !== e) begin
          bad++;
          $display("FAIL R1/R3 read data act=%0h exp=%0h", dout, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R11 act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state, R9 zero data
    chk(dout_en == 1'b0, "R11 dout_en after reset", dout_en, 0);
    chk(dout == 8'h00, "R11/R9 dout after reset", dout, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R4 write-enable controlled writes at both ends of the range
    wr_we(13'h0000, 8'hA5);
    wr_we(13'h1FFF, 8'h3C);
    wr_we(13'h0AAA, 8'h5A);
    do_read(13'h0000);
    do_read(13'h1FFF);
    do_read(13'h0AAA);

    // R4 select-controlled writes
    wr_cs_lo(13'h1555, 8'hC3);
    wr_cs_hi(13'h0123, 8'h96);
    do_read(13'h1555);
    do_read(13'h0123);
    do_read(13'h0AAA);

    // R3: output enable high gives no drive
    put(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 13'h0000, 8'h00);
    chk(dout_en == 1'b0, "R3 oe_n high no drive", dout_en, 0);
    // R2: each select inactive
    put(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 13'h0000, 8'h00);
    chk(dout_en == 1'b0, "R2 sel_n high no drive", dout_en, 0);
    put(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 13'h0000, 8'h00);
    chk(dout_en == 1'b0, "R2 sel low no drive", dout_en, 0);
    chk(dout == 8'h00, "R9 zero when idle", dout, 0);
    idle();

    // R5: write enable low during a read releases the output
    expq.push_back(shadow[13'h1FFF]);
    put(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 13'h1FFF, shadow[13'h1FFF]);
    chk(dout_en == 1'b1, "R3 read drives", dout_en, 1);
    put(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 13'h1FFF, shadow[13'h1FFF]);
    chk(dout_en == 1'b0, "R5 released after we_n low", dout_en, 0);
    expq.push_back(shadow[13'h1FFF]);
    put(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 13'h1FFF, shadow[13'h1FFF]);
    idle();

    // R6: select and write enable together keep output released; R10 forward
    put(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 13'h0777, 8'h4E);
    chk(dout_en == 1'b0, "R6 no drive at window start", dout_en, 0);
    put(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 13'h0777, 8'h4E);
    chk(dout_en == 1'b0, "R6 no drive in window", dout_en, 0);
    expq.push_back(8'h4E);
    put(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 13'h0777, 8'h4E);
    shadow[13'h0777] = 8'h4E;
    chk(dout_en == 1'b1 && dout == 8'h4E, "R10 forwarded commit", dout, 8'h4E);
    idle();
    do_read(13'h0777);

    // R7: lock blocks reads and writes
    put(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 13'h0000, 8'h00);
    chk(dout_en == 1'b0, "R7 no drive under lock", dout_en, 0);
    put(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 13'h0000, 8'hFF);
    put(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 13'h0000, 8'hFF);
    put(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 13'h0000, 8'hFF);
    put(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 13'h0000, 8'hFF);
    idle();
    do_read(13'h0000);

    // R8: window aborted by lock stays dead after lock release
    put(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 13'h0AAA, 8'h77);
    put(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 13'h0AAA, 8'h77);
    put(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 13'h0AAA, 8'h77);
    put(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 13'h0AAA, 8'h77);
    idle();
    do_read(13'h0AAA);
    do_read(13'h1555);
    // R8: a fresh window after release works again
    wr_we(13'h0AAA, 8'h81);
    do_read(13'h0AAA);

    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R3 every read was driven", expq.size(), 0);
    chk(dout_en == 1'b0 && dout == 8'h00, "R9 idle at end", dout, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule